// File: doc/BRIEF.md
# Multiplexed converter control and serial port

This block is the digital side of an eight-input successive-approximation converter. A single select/convert pin does two jobs. A rising edge on it launches a conversion that is timed internally and cannot be restarted. While it is low, a serial port is open. Through that port a host clocks in a seven-bit setup word and clocks out the last result.

During a conversion, the block produces a trial word for an external weighting network. It keeps or drops each trial bit from a comparator input, starting at the top bit and working down to the bottom bit. It then formats the final code by polarity and loads it for readout. It also tracks three power states (nap, stay-on and sleep with a timed wake-up) and decodes the channel selection for the analog multiplexer. The multiplexer, the weighting network and the comparator lie outside the block.

Top module: `muxadc_ctrl`

## Requirements
- R1: A conversion starts only from an idle state (napping or awake), on a clock where `sel_cnv` is sampled high after being low. Further rising edges during a conversion or during wake-up do not restart or start anything.
- R2: `busy_o` stays high for exactly RES*BIT_CYC clocks. During bit slot k (top bit first), `dac_trial` equals the bits already kept OR bit k. Bit k is kept when `cmp_hi` is 1 at the last clock of its slot, so the final code equals the largest trial value that the comparator accepts.
- R3: `sdo_en` is 1 exactly while `sel_cnv` is low, and 0 while it is high (the output is high-impedance).
- R4: While `sel_cnv` is low, the first seven rising `sck` edges shift `sdi` into a setup word, first bit received first. The fields, in the order received, are: differential/single-ended select SD, odd/sign OS, address bit A1, address bit A0, common-input select COM, unipolar UNI, sleep SLP. Further rising edges in the same frame are ignored.
- R5: `sdo` presents the loaded result from bit RES-1 downwards. The next bit appears after each falling `sck` edge while `sel_cnv` is low.
- R6: If `sel_cnv` is high when a conversion ends, `nap_o` becomes 1. If it is low, `nap_o` stays 0 and `sdo` shows the result's top bit on the first clock after `busy_o` falls.
- R7: With UNI=1 the result is the raw code (straight binary). With UNI=0 the top bit of the code is inverted (two's complement about mid-scale).
- R8: If the pending word has SLP=1, a select rise enters sleep instead of converting, and `asleep_o` is 1. A later select rise with a pending word of SLP=0 starts a wake-up of exactly WAKE_CYC clocks. During the wake-up `asleep_o` stays 1, and after it the block is idle.
- R9: `pos_ch` = 4·A1 + 2·A0 + OS. With SD=0, the negative input is the other member of the pair: `neg_ch` = pos_ch XOR 1 and `neg_kind` = 0. With SD=1 and COM=0, `neg_kind` = 1 (ground) and `neg_ch` = 0. With SD=1 and COM=1, `neg_kind` = 2 (channel 7 as common) and `neg_ch` = 7.
- R10: A received word is held as pending. It changes `pos_ch`, `neg_ch`, `neg_kind`, `unipolar_o` and the result format only when the next conversion starts, and stays fixed during that conversion.
- R11: A word with COM=1 and SD=0 leaves the pending channel fields (SD, OS, A1, A0, COM) unchanged. Its UNI and SLP bits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_cnv | input | 1 | Select/convert: a rising edge converts, a low level opens the port |
| sck | input | 1 | Serial shift clock (oversampled) |
| sdi | input | 1 | Serial setup-word input |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above `dac_trial` |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means high-impedance |
| dac_trial | output | RES | Trial word for the weighting network |
| busy_o | output | 1 | Conversion in progress |
| nap_o | output | 1 | Napping between conversions |
| asleep_o | output | 1 | In sleep or wake-up |
| unipolar_o | output | 1 | Polarity mode of the current conversion |
| pos_ch | output | 3 | Positive multiplexer input |
| neg_ch | output | 3 | Negative multiplexer input |
| neg_kind | output | 2 | 0 pair partner, 1 ground, 2 common input |

## Verification
The bench sweeps all 64 combinations of the five channel bits and the polarity bit. For each combination it clocks in the word and converts an arithmetically chosen input: the corner codes 0, all-ones and the two mid-scale codes, then a spread of values. This separates the pair, ground-referenced, common-input and invalid decodes, as well as the two output formats. Each conversion runs in one of three select patterns: held high, short pulse, and short pulse with an extra rise mid-conversion. These separate the nap outcome from the stay-on outcome with an immediate top bit, and show whether the extra edge restarts the conversion. Ones are driven on `sdi` past the seventh bit, so a port that takes surplus bits corrupts the next channel setting. A sleep and wake sequence, with a rise injected during wake-up, checks the wake length and confirms that no conversion occurs while asleep.

// File: rtl/muxadc_pkg.sv
package muxadc_pkg;

    localparam int CFG_W = 7;

    // Field order matches the order bits arrive on the serial input.
    typedef struct packed {
        logic sd;
        logic os;
        logic a1;
        logic a0;
        logic com;
        logic uni;
        logic slp;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_NAP   = 3'd0,
        ST_ON    = 3'd1,
        ST_CONV  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } pwr_state_t;

    typedef enum logic [1:0] {
        NEG_PAIR = 2'd0,
        NEG_GND  = 2'd1,
        NEG_COM  = 2'd2
    } neg_kind_t;

    function automatic logic cfg_valid(cfg_t c);
        return !(c.com && !c.sd);
    endfunction

    // Invalid words only update polarity and sleep fields.
    function automatic cfg_t cfg_merge(cfg_t prev, cfg_t nw);
        cfg_t r;
        if (cfg_valid(nw)) begin
            r = nw;
        end else begin
            r     = prev;
            r.uni = nw.uni;
            r.slp = nw.slp;
        end
        return r;
    endfunction

endpackage

// File: rtl/muxadc_sar.sv
module muxadc_sar #(
    parameter int RES     = 16,
    parameter int BIT_CYC = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cmp_hi,
    output logic           busy,
    output logic           done,
    output logic [RES-1:0] trial,
    output logic [RES-1:0] code
);
    localparam int IDX_W    = $clog2(RES);
    localparam int CYC_W    = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam int CONV_CYC = RES * BIT_CYC;
    localparam int LEN_W    = $clog2(CONV_CYC + 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [CYC_W-1:0] cyc;
        logic [RES-1:0]   sar;
    } sar_st_t;

    sar_st_t q, d;
    logic [RES-1:0] bit_mask;
    logic           slot_end;

    always_comb begin
        bit_mask = {{(RES-1){1'b0}}, 1'b1} << q.idx;
        trial    = q.active ? (q.sar | bit_mask) : q.sar;
        slot_end = q.active && (q.cyc == CYC_W'(BIT_CYC - 1));
        done     = slot_end && (q.idx == '0);
        code     = cmp_hi ? trial : q.sar;
        busy     = q.active;

        d = q;
        if (start && !q.active) begin
            d.active = 1'b1;
            d.idx    = IDX_W'(RES - 1);
            d.cyc    = '0;
            d.sar    = '0;
        end else if (q.active) begin
            if (slot_end) begin
                d.sar = cmp_hi ? trial : q.sar;
                d.cyc = '0;
                if (q.idx == '0) begin
                    d.active = 1'b0;
                end else begin
                    d.idx = q.idx - 1'b1;
                end
            end else begin
                d.cyc = q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Checker: conversion length counted independently of the slot logic.
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (start && !q.active) begin
            len_q <= '0;
        end else if (q.active) begin
            len_q <= len_q + 1'b1;
        end
    end

    a_r2_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_q == LEN_W'(CONV_CYC - 1)))
        else $error("R2: conversion length mismatch");

    a_r2_word_held_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !slot_end) |=> $stable(q.sar))
        else $error("R2: decided bits changed inside a slot");

endmodule

// File: rtl/muxadc_serial.sv
module muxadc_serial
    import muxadc_pkg::*;
#(
    parameter int RES = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_low,
    input  logic           sck_rise,
    input  logic           sck_fall,
    input  logic           sdi,
    input  logic           load,
    input  logic [RES-1:0] load_val,
    output logic           sdo_bit,
    output logic           word_valid,
    output cfg_t           word
);
    localparam int CNT_W = $clog2(CFG_W + 1);

    typedef struct packed {
        logic [RES-1:0]   sh_out;
        logic [CFG_W-1:0] sh_in;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } ser_st_t;

    ser_st_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;

        if (load) begin
            d.sh_out = load_val;
        end else if (sel_low && sck_fall) begin
            d.sh_out = {q.sh_out[RES-2:0], 1'b0};
        end

        if (!sel_low) begin
            d.cnt = '0;
        end else if (sck_rise && (q.cnt < CNT_W'(CFG_W))) begin
            d.sh_in = {q.sh_in[CFG_W-2:0], sdi};
            d.cnt   = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(CFG_W - 1)) begin
                d.valid = 1'b1;
            end
        end

        sdo_bit    = q.sh_out[RES-1];
        word_valid = q.valid;
        word       = cfg_t'(q.sh_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(CFG_W))
        else $error("R4: setup bit count overran");

    a_r4_frame_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_low |=> (q.cnt == '0))
        else $error("R4: bit count not cleared by a high select");

    a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_low && !load) |=> $stable(q.sh_out))
        else $error("R5: result moved while deselected");

endmodule

// File: rtl/muxadc_chdec.sv
module muxadc_chdec (
    input  logic       sd,
    input  logic       os,
    input  logic       a1,
    input  logic       a0,
    input  logic       com,
    output logic [2:0] pos_ch,
    output logic [2:0] neg_ch,
    output logic [1:0] neg_kind
);
    import muxadc_pkg::*;

    always_comb begin
        pos_ch = {a1, a0, os};
        if (!sd) begin
            neg_ch   = {a1, a0, ~os};
            neg_kind = NEG_PAIR;
        end else if (com) begin
            neg_ch   = 3'd7;
            neg_kind = NEG_COM;
        end else begin
            neg_ch   = 3'd0;
            neg_kind = NEG_GND;
        end
    end

    always_comb begin
        if (!$isunknown({sd, os, a1, a0, com}) && (neg_kind == NEG_PAIR)) begin
            a_r9_pair_adjacent: assert ((pos_ch[2:1] == neg_ch[2:1]) && (pos_ch[0] != neg_ch[0]))
                else $error("R9: pair members are not adjacent");
        end
    end

endmodule

// File: rtl/muxadc_ctrl.sv
module muxadc_ctrl
    import muxadc_pkg::*;
#(
    parameter int RES      = 16,
    parameter int BIT_CYC  = 4,
    parameter int WAKE_CYC = 6000000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_cnv,
    input  logic           sck,
    input  logic           sdi,
    input  logic           cmp_hi,
    output logic           sdo,
    output logic           sdo_en,
    output logic [RES-1:0] dac_trial,
    output logic           busy_o,
    output logic           nap_o,
    output logic           asleep_o,
    output logic           unipolar_o,
    output logic [2:0]     pos_ch,
    output logic [2:0]     neg_ch,
    output logic [1:0]     neg_kind
);
    localparam int WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        pwr_state_t        st;
        logic              sel_q;
        logic              sck_q;
        cfg_t              pend;
        cfg_t              act;
        logic [WAKE_W-1:0] wake;
    } top_st_t;

    top_st_t q, d;

    logic           sel_rise, sck_rise, sck_fall;
    logic           sar_start, sar_busy, sar_done;
    logic [RES-1:0] sar_code, load_val;
    logic           load;
    logic           sdo_bit, word_valid;
    cfg_t           word;

    muxadc_sar #(.RES(RES), .BIT_CYC(BIT_CYC)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sar_start),
        .cmp_hi (cmp_hi),
        .busy   (sar_busy),
        .done   (sar_done),
        .trial  (dac_trial),
        .code   (sar_code)
    );

    muxadc_serial #(.RES(RES)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_low    (!sel_cnv),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .sdi        (sdi),
        .load       (load),
        .load_val   (load_val),
        .sdo_bit    (sdo_bit),
        .word_valid (word_valid),
        .word       (word)
    );

    muxadc_chdec u_dec (
        .sd       (q.act.sd),
        .os       (q.act.os),
        .a1       (q.act.a1),
        .a0       (q.act.a0),
        .com      (q.act.com),
        .pos_ch   (pos_ch),
        .neg_ch   (neg_ch),
        .neg_kind (neg_kind)
    );

    always_comb begin
        sel_rise  = sel_cnv && !q.sel_q;
        sck_rise  = sck && !q.sck_q;
        sck_fall  = !sck && q.sck_q;
        sar_start = 1'b0;
        load      = 1'b0;
        load_val  = q.act.uni ? sar_code : {~sar_code[RES-1], sar_code[RES-2:0]};

        d       = q;
        d.sel_q = sel_cnv;
        d.sck_q = sck;
        if (word_valid) begin
            d.pend = cfg_merge(q.pend, word);
        end

        unique case (q.st)
            ST_NAP, ST_ON: begin
                if (sel_rise) begin
                    if (q.pend.slp) begin
                        d.st = ST_SLEEP;
                    end else begin
                        sar_start = 1'b1;
                        d.act     = q.pend;
                        d.st      = ST_CONV;
                    end
                end
            end
            ST_CONV: begin
                if (sar_done) begin
                    load = 1'b1;
                    d.st = sel_cnv ? ST_NAP : ST_ON;
                end
            end
            ST_SLEEP: begin
                if (sel_rise && !q.pend.slp) begin
                    d.st   = ST_WAKE;
                    d.wake = '0;
                end
            end
            ST_WAKE: begin
                if (q.wake == WAKE_W'(WAKE_CYC - 1)) begin
                    d.st = sel_cnv ? ST_NAP : ST_ON;
                end else begin
                    d.wake = q.wake + 1'b1;
                end
            end
            default: d.st = ST_NAP;
        endcase

        sdo        = sdo_bit;
        sdo_en     = !sel_cnv;
        busy_o     = (q.st == ST_CONV);
        nap_o      = (q.st == ST_NAP);
        asleep_o   = (q.st == ST_SLEEP) || (q.st == ST_WAKE);
        unipolar_o = q.act.uni;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_NAP;
            q.sel_q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    a_r1_start_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sel_cnv))
        else $error("R1: conversion began without a select rise");

    a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sel_rise && !sar_done) |=> (busy_o && sar_busy))
        else $error("R1: edge during conversion disturbed it");

    a_r6_nap_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sar_done && sel_cnv) |=> nap_o)
        else $error("R6: no nap after conversion with select high");

    a_r6_msb_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sar_done && !sel_cnv) |=> (!nap_o && (sdo == $past(load_val[RES-1]))))
        else $error("R6: top bit not presented at end of conversion");

    a_r10_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(q.act))
        else $error("R10: active settings changed mid-conversion");

    a_r8_no_conv_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |-> !sar_busy)
        else $error("R8: converting while asleep");

    a_r8_wake_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAKE) |-> (q.wake < WAKE_W'(WAKE_CYC)))
        else $error("R8: wake counter overran");

endmodule

// File: tb/muxadc_ctrl_test.sv
module muxadc_ctrl_test;
    localparam int CLK_P    = 10;
    localparam int RES      = 16;
    localparam int BIT_CYC  = 4;
    localparam int WAKE_CYC = 40;
    localparam int CONV_CYC = RES * BIT_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_cnv = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic [RES-1:0] vin = '0;
    logic cmp_hi;

    logic           sdo, sdo_en, busy_o, nap_o, asleep_o, unipolar_o;
    logic [RES-1:0] dac_trial;
    logic [2:0]     pos_ch, neg_ch;
    logic [1:0]     neg_kind;

    int n_run = 0;
    int n_fail = 0;

    logic [6:0]  pend_m = 7'd0;
    logic [15:0] exp_sh = 16'd0;
    int exp_pos = 0, exp_neg = 1, exp_kind = 0, exp_uni = 0;

    assign cmp_hi = (vin >= dac_trial);

    always #(CLK_P/2) clk = ~clk;

    muxadc_ctrl #(.RES(RES), .BIT_CYC(BIT_CYC), .WAKE_CYC(WAKE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .sel_cnv(sel_cnv), .sck(sck), .sdi(sdi),
        .cmp_hi(cmp_hi), .sdo(sdo), .sdo_en(sdo_en), .dac_trial(dac_trial),
        .busy_o(busy_o), .nap_o(nap_o), .asleep_o(asleep_o),
        .unipolar_o(unipolar_o), .pos_ch(pos_ch), .neg_ch(neg_ch),
        .neg_kind(neg_kind)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // One port frame: clock in a setup word, read the loaded result.
    task automatic frame(input logic [6:0] w);
        logic [15:0] got;
        sel_cnv = 1'b0;
        @(negedge clk);
        check("R3 enable with select low", sdo_en, 1);
        for (int i = 0; i < 16; i++) begin
            sdi = (i < 7) ? w[6-i] : 1'b1;   // surplus bits must be ignored (R4)
            repeat (2) @(negedge clk);
            got[15-i] = sdo;
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
            repeat (2) @(negedge clk);
        end
        check("R5 R7 serial readout", got, exp_sh);
        exp_sh = 16'd0;
        if (w[2] && !w[6]) pend_m = {pend_m[6:2], w[1:0]};
        else               pend_m = w;
        check("R10 word not yet applied", pos_ch, exp_pos);
    endtask

    // mode 0: select held high, 1: short pulse, 2: short pulse plus extra rise
    task automatic convert(input logic [15:0] v, input int mode, input bit was_invalid);
        int cnt;
        int s;
        vin = v;
        sel_cnv = 1'b1;
        @(posedge clk);
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!busy_o || cnt > 4 * CONV_CYC) break;
            cnt++;
            if (mode != 0 && cnt == 3)  sel_cnv = 1'b0;
            if (mode == 2 && cnt == 20) sel_cnv = 1'b1;
            if (mode == 2 && cnt == 30) sel_cnv = 1'b0;
        end
        if (mode == 2) check("R1 extra rise ignored", cnt, CONV_CYC);
        else           check("R2 conversion length", cnt, CONV_CYC);

        exp_uni = pend_m[1];
        exp_sh  = exp_uni ? v : (v ^ 16'h8000);
        s       = pend_m[4] * 2 + pend_m[3];
        exp_pos = s * 2 + pend_m[5];
        if (!pend_m[6]) begin
            exp_neg  = s * 2 + (1 - pend_m[5]);
            exp_kind = 0;
        end else if (pend_m[2]) begin
            exp_neg  = 7;
            exp_kind = 2;
        end else begin
            exp_neg  = 0;
            exp_kind = 1;
        end

        check("R6 nap outcome", nap_o, (mode == 0));
        check("R3 enable follows select", sdo_en, (mode != 0));
        if (mode != 0) check("R6 top bit at end", sdo, exp_sh[15]);
        if (was_invalid) begin
            check("R11 channel kept pos", pos_ch, exp_pos);
            check("R11 channel kept neg", neg_ch, exp_neg);
        end else begin
            check("R4 R9 positive input", pos_ch, exp_pos);
            check("R9 negative input", neg_ch, exp_neg);
        end
        check("R9 negative kind", neg_kind, exp_kind);
        check("R10 polarity applied", unipolar_o, exp_uni);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset busy", busy_o, 0);
        check("R6 reset nap", nap_o, 1);
        check("R8 reset asleep", asleep_o, 0);
        check("R3 reset enable", sdo_en, 0);
        check("R9 reset pos", pos_ch, 0);
        check("R9 reset neg", neg_ch, 1);
        check("R9 reset kind", neg_kind, 0);
        check("R7 reset polarity", unipolar_o, 0);

        for (int k = 0; k < 64; k++) begin
            logic [5:0]  kk;
            logic [6:0]  w;
            logic [15:0] v;
            kk = 6'(k);
            w  = {kk[4], kk[3], kk[2], kk[1], kk[0], kk[5], 1'b0};
            case (k)
                0:       v = 16'h0000;
                1:       v = 16'hFFFF;
                2:       v = 16'h8000;
                3:       v = 16'h7FFF;
                default: v = 16'((k * 40503 + 12345) % 65536);
            endcase
            frame(w);
            convert(v, k % 3, (w[2] && !w[6]));
        end

        // Sleep entry: no conversion happens on the rise (R8)
        frame(7'b1011001);
        sel_cnv = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 asleep after rise", asleep_o, 1);
        check("R8 no conversion when asleep", busy_o, 0);
        check("R8 channel untouched", pos_ch, exp_pos);

        // Release: word with sleep clear, then timed wake-up
        frame(7'b1100010);
        check("R8 still asleep before rise", asleep_o, 1);
        sel_cnv = 1'b1;
        @(posedge clk);
        begin
            int cnt;
            cnt = 0;
            forever begin
                @(negedge clk);
                if (!asleep_o || cnt > 10 * WAKE_CYC) break;
                cnt++;
                if (cnt == 5) sel_cnv = 1'b0;
                if (cnt == 8) sel_cnv = 1'b1;
                if (cnt == 12) check("R1 R8 rise ignored during wake", busy_o, 0);
            end
            check("R8 wake length", cnt, WAKE_CYC);
        end
        check("R8 idle after wake", nap_o, 1);
        sel_cnv = 1'b0;
        @(negedge clk);
        convert(16'h1234, 0, 1'b0);
        frame(7'b0000000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule